// File: doc/BRIEF.md
# Associative TLB Entry Array

This block is the storage and match core of a fully associative translation buffer. It holds a parameterised number of entries. Each entry carries an address-space identifier, a global flag, a virtual page tag and a per-entry page mask that widens the page size. It also maps a pair of adjacent pages: an even page and an odd page, each with its own frame number, cache attribute, dirty bit and valid bit. Address-segment decoding, fault generation and physical address composition are left to the surrounding logic.

Three independent paths share the table. A lookup port returns the fields of the matching entry in the same cycle. A probe port returns only the index of the match, or a negative value when nothing matches. A victim port shows the entry at a round-robin replacement pointer and can step that pointer, so that refill software can pick a slot. Writes go to an explicit index, and a flush input clears the whole table.

Top module: `tlbx_assoc_array`

## Requirements
- R1: After reset or after a cycle with `flush` high, every field of every entry reads zero, no lookup hits, the probe reports not found, and the victim pointer is 0.
- R2: The VPN part of a match compares the request VPN with the stored VPN only in the bit positions where the stored mask holds a 0. Bits set in the mask are don't-care.
- R3: The ASID part of a match passes when the entry is global or the request ASID equals the stored ASID. A written entry is global only when bit 0 of both `wr_lo_even` and `wr_lo_odd` is 1.
- R4: An entry whose even and odd valid bits are both 0 never matches.
- R5: When several entries match, the lowest index is reported on both the lookup port and the probe port. Lookup and probe results are combinational from their request inputs.
- R6: `pr_index` is the matching index zero-extended to IDX_W+1 bits, or all ones (-1) when nothing matches.
- R7: With `wr_en` high, the whole entry at `wr_index` is replaced at the clock edge. A `wr_index` of NUM_ENTRIES or more leaves every entry unchanged.
- R8: Readback formats are as follows. The low word is {PFN, cache[2:0], dirty, valid, global}, with PFN at bit 6 upward, the cache attribute at bits 5:3, dirty at bit 2, valid at bit 1 and global at bit 0. The high word has the VPN at bit 11 upward, zero in bits 10:8 and the ASID in bits 7:0. On a lookup miss, every lookup field output reads zero.
- R9: The victim port always shows the entry at the pointer. Each cycle with `vr_adv` high steps the pointer by one, and it wraps from NUM_ENTRIES-1 to 0. Without `vr_adv`, the pointer holds.
- R10: `flush` takes priority over a same-cycle write and over a same-cycle pointer step.
- R11: A lookup made in the same cycle as a write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear all entries and the victim pointer |
| wr_en | input | 1 | Write strobe |
| wr_index | input | IDX_W+1 | Target entry; out-of-range values are ignored |
| wr_mask | input | VPN_W | Page mask of the new entry |
| wr_vpn | input | VPN_W | VPN tag of the new entry |
| wr_asid | input | ASID_W | ASID of the new entry |
| wr_lo_even | input | LO_W | Even-page low word |
| wr_lo_odd | input | LO_W | Odd-page low word |
| lk_vpn | input | VPN_W | Lookup VPN |
| lk_asid | input | ASID_W | Lookup ASID |
| lk_hit | output | 1 | Lookup matched |
| lk_index | output | IDX_W | Index of the matching entry |
| lk_mask | output | VPN_W | Mask of the matching entry |
| lk_hi | output | HI_W | High word of the matching entry |
| lk_lo_even | output | LO_W | Even low word of the matching entry |
| lk_lo_odd | output | LO_W | Odd low word of the matching entry |
| pr_vpn | input | VPN_W | Probe VPN |
| pr_asid | input | ASID_W | Probe ASID |
| pr_index | output | IDX_W+1 | Probe result, all ones when not found |
| vr_adv | input | 1 | Step the victim pointer |
| vr_index | output | IDX_W | Victim pointer |
| vr_mask | output | VPN_W | Mask of the entry at the pointer |
| vr_hi | output | HI_W | High word of the entry at the pointer |
| vr_lo_even | output | LO_W | Even low word of the entry at the pointer |
| vr_lo_odd | output | LO_W | Odd low word of the entry at the pointer |

## Verification
A write and a lookup of the very entry being written can land in the same cycle. The bench drives both on one edge and expects a miss. It then expects a hit one cycle later, which confirms that the combinational match reads the old contents. A flush can likewise coincide with a write and a pointer step. The bench raises all three together and requires that the written VPN misses afterwards and that the pointer sits at 0.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int ASID_W = 8;
    localparam int VPN_W  = 21;
    localparam int PFN_W  = 20;
    localparam int CA_W   = 3;
    localparam int VPN_SH = 11;
    localparam int LO_W   = PFN_W + CA_W + 3;
    localparam int HI_W   = VPN_W + VPN_SH;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic [CA_W-1:0]  cattr;
        logic             dirty;
        logic             valid;
    } page_t;

    typedef struct packed {
        logic [VPN_W-1:0]  mask;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        page_t             even;
        page_t             odd;
    } entry_t;

    // Only the fields the comparators need
    typedef struct packed {
        logic [VPN_W-1:0]  mask;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              active;
    } key_t;

    function automatic key_t key_of(entry_t e);
        key_t k;
        k.mask   = e.mask;
        k.vpn    = e.vpn;
        k.asid   = e.asid;
        k.glob   = e.glob;
        k.active = e.even.valid | e.odd.valid;
        return k;
    endfunction

    function automatic logic key_hits(key_t k, logic [VPN_W-1:0] vpn,
                                      logic [ASID_W-1:0] asid);
        logic tag_ok;
        logic id_ok;
        tag_ok = ((vpn ^ k.vpn) & ~k.mask) == '0;
        id_ok  = k.glob | (asid == k.asid);
        return k.active & tag_ok & id_ok;
    endfunction

    function automatic page_t lo_unpack(logic [LO_W-1:0] w);
        page_t p;
        p.pfn   = w[LO_W-1:CA_W+3];
        p.cattr = w[CA_W+2:3];
        p.dirty = w[2];
        p.valid = w[1];
        return p;
    endfunction

    function automatic logic [LO_W-1:0] lo_pack(page_t p, logic g);
        return {p.pfn, p.cattr, p.dirty, p.valid, g};
    endfunction

    function automatic logic [HI_W-1:0] hi_pack(logic [VPN_W-1:0] vpn,
                                                logic [ASID_W-1:0] asid);
        logic [HI_W-1:0] h;
        h = '0;
        h[HI_W-1:VPN_SH] = vpn;
        h[ASID_W-1:0]    = asid;
        return h;
    endfunction

endpackage

// File: rtl/tlbx_match_bank.sv
module tlbx_match_bank
    import tlbx_pkg::*;
#(
    parameter int N = 16
) (
    input  key_t              keys [N],
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    output logic [N-1:0]      hits
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = key_hits(keys[g], req_vpn, req_asid);
    end

endmodule

// File: rtl/tlbx_first_hit.sv
module tlbx_first_hit #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        // scan downward so the lowest set bit is the last assignment
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlbx_victim_ptr.sv
module tlbx_victim_ptr #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlbx_assoc_array.sv
module tlbx_assoc_array
    import tlbx_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W:0]    wr_index,
    input  logic [VPN_W-1:0]  wr_mask,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [LO_W-1:0]   wr_lo_even,
    input  logic [LO_W-1:0]   wr_lo_odd,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_index,
    output logic [VPN_W-1:0]  lk_mask,
    output logic [HI_W-1:0]   lk_hi,
    output logic [LO_W-1:0]   lk_lo_even,
    output logic [LO_W-1:0]   lk_lo_odd,
    input  logic [VPN_W-1:0]  pr_vpn,
    input  logic [ASID_W-1:0] pr_asid,
    output logic [IDX_W:0]    pr_index,
    input  logic              vr_adv,
    output logic [IDX_W-1:0]  vr_index,
    output logic [VPN_W-1:0]  vr_mask,
    output logic [HI_W-1:0]   vr_hi,
    output logic [LO_W-1:0]   vr_lo_even,
    output logic [LO_W-1:0]   vr_lo_odd
);

    entry_t           tbl [NUM_ENTRIES];
    key_t             keys [NUM_ENTRIES];
    entry_t           wr_entry;
    logic             wr_in_range;
    logic [NUM_ENTRIES-1:0] lk_vec;
    logic [NUM_ENTRIES-1:0] pr_vec;
    logic             pr_found;
    logic [IDX_W-1:0] pr_idx;
    entry_t           lk_sel;
    entry_t           vr_sel;

    // ---------------- write path ----------------
    assign wr_in_range = int'(wr_index) < NUM_ENTRIES;

    always_comb begin
        wr_entry      = '0;
        wr_entry.mask = wr_mask;
        wr_entry.vpn  = wr_vpn;
        wr_entry.asid = wr_asid;
        wr_entry.glob = wr_lo_even[0] & wr_lo_odd[0];
        wr_entry.even = lo_unpack(wr_lo_even);
        wr_entry.odd  = lo_unpack(wr_lo_odd);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en && wr_in_range) begin
            tbl[wr_index[IDX_W-1:0]] <= wr_entry;
        end
    end

    // ---------------- match paths ----------------
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_key
        assign keys[g] = key_of(tbl[g]);
    end

    tlbx_match_bank #(.N(NUM_ENTRIES)) u_lk_bank (
        .keys     (keys),
        .req_vpn  (lk_vpn),
        .req_asid (lk_asid),
        .hits     (lk_vec)
    );

    tlbx_match_bank #(.N(NUM_ENTRIES)) u_pr_bank (
        .keys     (keys),
        .req_vpn  (pr_vpn),
        .req_asid (pr_asid),
        .hits     (pr_vec)
    );

    tlbx_first_hit #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
        .req   (lk_vec),
        .found (lk_hit),
        .idx   (lk_index)
    );

    tlbx_first_hit #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pr_pick (
        .req   (pr_vec),
        .found (pr_found),
        .idx   (pr_idx)
    );

    assign pr_index = pr_found ? {1'b0, pr_idx} : '1;

    assign lk_sel     = lk_hit ? tbl[lk_index] : '0;
    assign lk_mask    = lk_sel.mask;
    assign lk_hi      = hi_pack(lk_sel.vpn, lk_sel.asid);
    assign lk_lo_even = lo_pack(lk_sel.even, lk_sel.glob);
    assign lk_lo_odd  = lo_pack(lk_sel.odd, lk_sel.glob);

    // ---------------- victim path ----------------
    tlbx_victim_ptr #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk   (clk),
        .rst   (rst),
        .clear (flush),
        .adv   (vr_adv),
        .ptr   (vr_index)
    );

    assign vr_sel     = tbl[vr_index];
    assign vr_mask    = vr_sel.mask;
    assign vr_hi      = hi_pack(vr_sel.vpn, vr_sel.asid);
    assign vr_lo_even = lo_pack(vr_sel.even, vr_sel.glob);
    assign vr_lo_odd  = lo_pack(vr_sel.odd, vr_sel.glob);

endmodule

// File: rtl/tlbx_assoc_array_chk.sv
module tlbx_assoc_array_chk
    import tlbx_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic [VPN_W-1:0]  pr_vpn,
    input logic [ASID_W-1:0] pr_asid,
    input logic              lk_hit,
    input logic [IDX_W-1:0]  lk_index,
    input logic [IDX_W:0]    pr_index,
    input logic              lk_valid_e,
    input logic              lk_valid_o,
    input logic              vr_adv,
    input logic [IDX_W-1:0]  vr_index
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

    // R1
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!lk_hit && pr_index == '1 && vr_index == '0));

    // R5
    probe_agrees_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_vpn == pr_vpn && lk_asid == pr_asid) |->
        (lk_hit ? (pr_index == {1'b0, lk_index}) : (pr_index == '1)));

    // R4
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_valid_e || lk_valid_o));

    // R9
    victim_step_chk: assert property (@(posedge clk) disable iff (rst)
        (vr_adv && !flush) |=>
        (vr_index == (($past(vr_index) == LAST) ? '0 : $past(vr_index) + 1'b1)));

    // R9
    victim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!vr_adv && !flush) |=> $stable(vr_index));

endmodule

bind tlbx_assoc_array tlbx_assoc_array_chk #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .lk_vpn     (lk_vpn),
    .lk_asid    (lk_asid),
    .pr_vpn     (pr_vpn),
    .pr_asid    (pr_asid),
    .lk_hit     (lk_hit),
    .lk_index   (lk_index),
    .pr_index   (pr_index),
    .lk_valid_e (lk_lo_even[1]),
    .lk_valid_o (lk_lo_odd[1]),
    .vr_adv     (vr_adv),
    .vr_index   (vr_index)
);

// File: tb/tlbx_assoc_array_bench.sv
`timescale 1ns/1ps
module tlbx_assoc_array_bench;
    import tlbx_pkg::*;

    localparam int N     = 16;
    localparam int IDX_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flush = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W:0]    wr_index = '0;
    logic [VPN_W-1:0]  wr_mask = '0;
    logic [VPN_W-1:0]  wr_vpn = '0;
    logic [ASID_W-1:0] wr_asid = '0;
    logic [LO_W-1:0]   wr_lo_even = '0;
    logic [LO_W-1:0]   wr_lo_odd = '0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_index;
    logic [VPN_W-1:0]  lk_mask;
    logic [HI_W-1:0]   lk_hi;
    logic [LO_W-1:0]   lk_lo_even;
    logic [LO_W-1:0]   lk_lo_odd;
    logic [VPN_W-1:0]  pr_vpn = '0;
    logic [ASID_W-1:0] pr_asid = '0;
    logic [IDX_W:0]    pr_index;
    logic              vr_adv = 1'b0;
    logic [IDX_W-1:0]  vr_index;
    logic [VPN_W-1:0]  vr_mask;
    logic [HI_W-1:0]   vr_hi;
    logic [LO_W-1:0]   vr_lo_even;
    logic [LO_W-1:0]   vr_lo_odd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tlbx_assoc_array #(.NUM_ENTRIES(N)) u_tlbx_assoc_array (.*);

    function automatic logic [LO_W-1:0] mk_lo(logic [PFN_W-1:0] pfn, logic [2:0] c,
                                              logic d, logic v, logic g);
        return {pfn, c, d, v, g};
    endfunction

    function automatic logic [HI_W-1:0] mk_hi(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] a);
        return {vpn, 3'b000, a};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [VPN_W-1:0] mask, input logic [VPN_W-1:0] vpn,
                       input logic [ASID_W-1:0] a, input logic [LO_W-1:0] le,
                       input logic [LO_W-1:0] lo);
        @(negedge clk);
        wr_en = 1'b1; wr_index = (IDX_W+1)'(idx); wr_mask = mask; wr_vpn = vpn;
        wr_asid = a; wr_lo_even = le; wr_lo_odd = lo;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] a);
        lk_vpn = vpn; lk_asid = a; pr_vpn = vpn; pr_asid = a;
        #1;
    endtask

    task automatic t_reset;
        look(21'h0, 8'h0);
        chk("R1 reset no hit", 64'(lk_hit), 64'd0);
        chk("R6 reset probe -1", 64'(pr_index), 64'h1F);
        chk("R1 reset victim ptr", 64'(vr_index), 64'd0);
        chk("R1 reset entry zero", 64'(vr_hi), 64'd0);
        chk("R8 miss fields zero", 64'(lk_hi), 64'd0);
    endtask

    task automatic t_asid;
        put(3, '0, 21'h12345, 8'h05, mk_lo(20'hABCDE, 3'd3, 1'b1, 1'b1, 1'b0),
            mk_lo(20'h11111, 3'd2, 1'b0, 1'b1, 1'b0));
        look(21'h12345, 8'h05);
        chk("R3 asid hit", 64'(lk_hit), 64'd1);
        chk("R7 index", 64'(lk_index), 64'd3);
        chk("R8 hi word", 64'(lk_hi), 64'(mk_hi(21'h12345, 8'h05)));
        chk("R8 lo even", 64'(lk_lo_even), 64'(mk_lo(20'hABCDE, 3'd3, 1'b1, 1'b1, 1'b0)));
        chk("R8 lo odd", 64'(lk_lo_odd), 64'(mk_lo(20'h11111, 3'd2, 1'b0, 1'b1, 1'b0)));
        chk("R6 probe index", 64'(pr_index), 64'd3);
        look(21'h12345, 8'h06);
        chk("R3 asid mismatch", 64'(lk_hit), 64'd0);
        chk("R6 probe miss", 64'(pr_index), 64'h1F);
    endtask

    task automatic t_global;
        put(5, '0, 21'h00777, 8'h09, mk_lo(20'h1, 3'd0, 1'b0, 1'b1, 1'b1),
            mk_lo(20'h2, 3'd0, 1'b0, 1'b1, 1'b1));
        look(21'h00777, 8'hEE);
        chk("R3 global any asid", 64'(lk_hit), 64'd1);
        chk("R3 global index", 64'(lk_index), 64'd5);
        chk("R8 global bit", 64'(lk_lo_odd[0]), 64'd1);
        put(6, '0, 21'h00888, 8'h09, mk_lo(20'h3, 3'd0, 1'b0, 1'b1, 1'b1),
            mk_lo(20'h4, 3'd0, 1'b0, 1'b1, 1'b0));
        look(21'h00888, 8'hEE);
        chk("R3 half global not global", 64'(lk_hit), 64'd0);
        look(21'h00888, 8'h09);
        chk("R3 own asid hit", 64'(lk_index), 64'd6);
        chk("R8 global cleared", 64'(lk_lo_even[0]), 64'd0);
    endtask

    task automatic t_mask;
        put(7, 21'h0000F, 21'h0AB30, 8'h01, mk_lo(20'h5, 3'd1, 1'b1, 1'b1, 1'b0),
            mk_lo(20'h6, 3'd1, 1'b1, 1'b1, 1'b0));
        look(21'h0AB3F, 8'h01);
        chk("R2 masked bits ignored", 64'(lk_hit), 64'd1);
        chk("R2 masked index", 64'(lk_index), 64'd7);
        chk("R8 mask readback", 64'(lk_mask), 64'h0000F);
        look(21'h0AB20, 8'h01);
        chk("R2 unmasked bit compared", 64'(lk_hit), 64'd0);
    endtask

    task automatic t_valid;
        put(2, '0, 21'h05550, 8'h01, mk_lo(20'h7, 3'd0, 1'b0, 1'b0, 1'b1),
            mk_lo(20'h8, 3'd0, 1'b0, 1'b0, 1'b1));
        look(21'h05550, 8'h01);
        chk("R4 invalid pair no match", 64'(lk_hit), 64'd0);
        put(2, '0, 21'h05550, 8'h01, mk_lo(20'h7, 3'd0, 1'b0, 1'b0, 1'b1),
            mk_lo(20'h8, 3'd0, 1'b0, 1'b1, 1'b1));
        look(21'h05550, 8'h01);
        chk("R4 odd valid matches", 64'(lk_hit), 64'd1);
        chk("R4 index", 64'(lk_index), 64'd2);
    endtask

    task automatic t_prio;
        put(9, '0, 21'h1F000, 8'h00, mk_lo(20'h9, 3'd0, 1'b0, 1'b1, 1'b1),
            mk_lo(20'h9, 3'd0, 1'b0, 1'b1, 1'b1));
        put(4, '0, 21'h1F000, 8'h00, mk_lo(20'hA, 3'd0, 1'b0, 1'b1, 1'b1),
            mk_lo(20'hA, 3'd0, 1'b0, 1'b1, 1'b1));
        look(21'h1F000, 8'h33);
        chk("R5 lowest index lookup", 64'(lk_index), 64'd4);
        chk("R5 lowest index probe", 64'(pr_index), 64'd4);
        chk("R5 lowest entry fields", 64'(lk_lo_even[LO_W-1:6]), 64'hA);
    endtask

    task automatic t_range;
        put(0, '0, 21'h00ABC, 8'h02, mk_lo(20'hB, 3'd0, 1'b0, 1'b1, 1'b0),
            mk_lo(20'hC, 3'd0, 1'b0, 1'b1, 1'b0));
        put(16, '0, 21'h0DEF0, 8'h02, mk_lo(20'hD, 3'd0, 1'b0, 1'b1, 1'b0),
            mk_lo(20'hE, 3'd0, 1'b0, 1'b1, 1'b0));
        look(21'h0DEF0, 8'h02);
        chk("R7 out-of-range write ignored", 64'(lk_hit), 64'd0);
        look(21'h00ABC, 8'h02);
        chk("R7 entry 0 untouched", 64'(lk_index), 64'd0);
        chk("R7 entry 0 hit", 64'(lk_hit), 64'd1);
    endtask

    task automatic t_write_lookup;
        @(negedge clk);
        wr_en = 1'b1; wr_index = 5'd10; wr_mask = '0; wr_vpn = 21'h13131; wr_asid = 8'h03;
        wr_lo_even = mk_lo(20'hF, 3'd0, 1'b0, 1'b1, 1'b0);
        wr_lo_odd  = mk_lo(20'hF, 3'd0, 1'b0, 1'b1, 1'b0);
        look(21'h13131, 8'h03);
        chk("R11 same-cycle lookup sees old", 64'(lk_hit), 64'd0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R11 next cycle hit", 64'(lk_hit), 64'd1);
        chk("R7 written index", 64'(lk_index), 64'd10);
    endtask

    task automatic t_victim;
        look(21'h0, 8'h0);
        chk("R9 pointer at 0", 64'(vr_index), 64'd0);
        chk("R9 victim fields", 64'(vr_hi), 64'(mk_hi(21'h00ABC, 8'h02)));
        vr_adv = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            chk("R9 step/wrap", 64'(vr_index), 64'(k % N));
        end
        vr_adv = 1'b0;
        @(negedge clk);
        chk("R9 hold", 64'(vr_index), 64'd1);
        chk("R9 entry 1 empty", 64'(vr_lo_even), 64'd0);
    endtask

    task automatic t_flush_collide;
        @(negedge clk);
        flush = 1'b1; vr_adv = 1'b1;
        wr_en = 1'b1; wr_index = 5'd11; wr_mask = '0; wr_vpn = 21'h07070; wr_asid = 8'h00;
        wr_lo_even = mk_lo(20'h1, 3'd0, 1'b0, 1'b1, 1'b1);
        wr_lo_odd  = mk_lo(20'h1, 3'd0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        flush = 1'b0; vr_adv = 1'b0; wr_en = 1'b0;
        look(21'h07070, 8'h00);
        chk("R10 flush beats write", 64'(lk_hit), 64'd0);
        chk("R10 flush beats step", 64'(vr_index), 64'd0);
        look(21'h12345, 8'h05);
        chk("R1 flush clears entries", 64'(lk_hit), 64'd0);
        chk("R1 flush probe -1", 64'(pr_index), 64'h1F);
        chk("R1 flush entry 0 zero", 64'(vr_mask) | 64'(vr_lo_odd), 64'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_asid();
        t_global();
        t_mask();
        t_valid();
        t_prio();
        t_range();
        t_write_lookup();
        t_victim();
        t_flush_collide();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule